// File: doc/BRIEF.md
# Byte-Lane Sequencer for a 16-bit Port

This block connects a 16-bit external data port to a byte-wide internal stream. In the port-to-stream direction it splits each port word into bytes. In the stream-to-port direction it packs bytes into port words. A direction bit, captured at start, selects which path is active. Three mode bits, also captured at start, control the transfer:

- **Narrow mode** uses only the low lane of the port.
- **Lane swap** reverses the order of the two lanes.
- **Odd start** makes the first word carry only one byte.

A byte count, loaded at start, decides when the last word holds a single byte. It also decides when the transfer ends. Both sides use valid/ready handshakes.

Lane ordering works as follows. Lane 0 is bits 7:0 and lane 1 is bits 15:8. The "leading lane" is lane 0 when swap is clear and lane 1 when swap is set. The other lane is the "trailing lane". A word always moves its leading lane before its trailing lane.

Top module: `lane_seq_top`

## Requirements
- R1: After reset, and whenever no transfer is active, the block holds these outputs low: `busy`, `byte_out_valid`, `byte_in_ready`, `port_in_ready` and `port_out_valid`.
- R2: A `start` pulse while idle captures `xfer_len`, `to_port`, `mode_narrow`, `mode_swap` and `mode_odd`. A length of zero starts nothing. A `start` pulse, or a change of any mode input, during a transfer has no effect on that transfer.
- R3: In wide mode with swap clear, each word moves bits 7:0 first and bits 15:8 second.
- R4: In wide mode with swap set, each word moves bits 15:8 first and bits 7:0 second.
- R5: In wide mode with odd start set, the first word carries only its trailing lane. With swap clear that is bits 15:8, and with swap set it is bits 7:0. The leading lane of that word is dropped when unpacking and written as zero when packing.
- R6: When one byte remains at the start of a word, it travels alone on the leading lane. When packing, the trailing lane of that word is zero.
- R7: In narrow mode each port word carries one byte on bits 7:0. Bits 15:8 of incoming words are ignored, and bits 15:8 of outgoing words are zero. Swap and odd start have no effect in this mode.
- R8: When unpacking, `port_in_ready` is high only in the cycle in which the last retained byte of the current word is accepted on the stream side.
- R9: When packing, a word is offered after its last byte is accepted. It holds its data stable until `port_out_ready`, and no byte is accepted while it is pending.
- R10: Each accepted byte decrements the remaining count by one. `busy` falls once the count reaches zero and no packed word is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (honoured only while idle) |
| xfer_len | input | CNT_W | Number of bytes in the transfer |
| to_port | input | 1 | 1: pack stream bytes into port words; 0: split port words into bytes |
| mode_narrow | input | 1 | Narrow (8-bit) port mode |
| mode_swap | input | 1 | Lane swap: bits 15:8 form the leading lane |
| mode_odd | input | 1 | First word carries only its trailing lane |
| port_in_valid | input | 1 | Incoming port word valid |
| port_in_ready | output | 1 | Incoming port word consumed |
| port_in_data | input | 2*LANE_W | Incoming port word |
| port_out_valid | output | 1 | Outgoing port word valid |
| port_out_ready | input | 1 | Outgoing port word accepted |
| port_out_data | output | 2*LANE_W | Outgoing port word |
| byte_in_valid | input | 1 | Incoming stream byte valid |
| byte_in_ready | output | 1 | Incoming stream byte accepted |
| byte_in_data | input | LANE_W | Incoming stream byte |
| byte_out_valid | output | 1 | Outgoing stream byte valid |
| byte_out_ready | input | 1 | Outgoing stream byte accepted |
| byte_out_data | output | LANE_W | Outgoing stream byte |
| busy | output | 1 | Transfer in progress |

## Verification
The assertions check the following properties on every cycle:
- The word-consume strobe only coincides with an accepted byte.
- A pending packed word stays stable under backpressure.
- Each accepted byte takes exactly one off the count.
- A start pulse in mid-transfer leaves the count alone.
- The upper lane is zero on narrow-mode output words.
- The block stays quiet when idle.

Only the bench scenarios can show that bytes come out in the right lane order for every combination of swap, odd start and a lone last byte. They also show that zero-filled lanes land on the correct side, and that each transfer consumes or produces the right number of words.

// File: rtl/lane_seq_pkg.sv
`timescale 1ns/1ps
package lane_seq_pkg;

  // Physical lane for a logical slot: slot 0 is the leading lane, slot 1 the trailing lane.
  // Returns 1 when the slot maps to bits 15:8.
  function automatic logic lane_hi(input logic narrow, input logic swap, input logic slot);
    return !narrow && (swap ^ slot);
  endfunction

  // A word closes on its trailing slot, on its final byte, or after one byte in narrow mode.
  function automatic logic word_last(input logic narrow, input logic slot, input logic one_left);
    return narrow || slot || one_left;
  endfunction

endpackage

// File: rtl/lane_seq_ctrl.sv
`timescale 1ns/1ps
module lane_seq_ctrl
  import lane_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  input  logic             to_port,
  input  logic             narrow,
  input  logic             swap,
  input  logic             odd,
  input  logic             byte_fire,
  output logic             cnt_busy,
  output logic [CNT_W-1:0] remaining,
  output logic             m_to_port,
  output logic             m_narrow,
  output logic             m_swap,
  output logic             slot,
  output logic             last_in_word,
  output logic             word_done
);

  logic [CNT_W-1:0] rem_q;
  logic             pos_q;
  logic             odd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q     <= '0;
      pos_q     <= 1'b0;
      odd_q     <= 1'b0;
      m_to_port <= 1'b0;
      m_narrow  <= 1'b0;
      m_swap    <= 1'b0;
    end else if (load) begin
      rem_q     <= len;
      pos_q     <= 1'b0;
      odd_q     <= odd && !narrow;
      m_to_port <= to_port;
      m_narrow  <= narrow;
      m_swap    <= swap;
    end else if (byte_fire) begin
      rem_q <= rem_q - CNT_W'(1);
      if (last_in_word) begin
        pos_q <= 1'b0;
        odd_q <= 1'b0;
      end else begin
        pos_q <= 1'b1;
      end
    end
  end

  assign remaining    = rem_q;
  assign cnt_busy     = (rem_q != '0);
  assign slot         = odd_q | pos_q;
  assign last_in_word = word_last(m_narrow, slot, rem_q == CNT_W'(1));
  assign word_done    = byte_fire && last_in_word;

endmodule

// File: rtl/lane_seq_unpack.sv
`timescale 1ns/1ps
module lane_seq_unpack #(
  parameter int LANE_W = 8,
  localparam int PORT_W = 2 * LANE_W
) (
  input  logic              active,
  input  logic              port_in_valid,
  input  logic [PORT_W-1:0] port_in_data,
  input  logic              lane_high,
  input  logic              last_in_word,
  input  logic              byte_out_ready,
  output logic              byte_out_valid,
  output logic [LANE_W-1:0] byte_out_data,
  output logic              port_in_ready
);

  assign byte_out_valid = active && port_in_valid;
  assign byte_out_data  = lane_high ? port_in_data[PORT_W-1:LANE_W] : port_in_data[LANE_W-1:0];
  assign port_in_ready  = byte_out_valid && byte_out_ready && last_in_word;

endmodule

// File: rtl/lane_seq_pack.sv
`timescale 1ns/1ps
module lane_seq_pack #(
  parameter int LANE_W = 8,
  localparam int PORT_W = 2 * LANE_W,
  localparam int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              byte_fire,
  input  logic              lane_high,
  input  logic              word_done,
  input  logic [LANE_W-1:0] byte_in_data,
  input  logic              port_out_ready,
  output logic              port_out_valid,
  output logic [PORT_W-1:0] port_out_data
);

  logic sent;
  assign sent = port_out_valid && port_out_ready;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic IS_HI = (g == 1);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        port_out_data[g*LANE_W +: LANE_W] <= '0;
      end else if (clear || sent) begin
        port_out_data[g*LANE_W +: LANE_W] <= '0;
      end else if (byte_fire && (lane_high == IS_HI)) begin
        port_out_data[g*LANE_W +: LANE_W] <= byte_in_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_out_valid <= 1'b0;
    end else if (clear || sent) begin
      port_out_valid <= 1'b0;
    end else if (word_done) begin
      port_out_valid <= 1'b1;
    end
  end

endmodule

// File: rtl/lane_seq_top.sv
`timescale 1ns/1ps
module lane_seq_top
  import lane_seq_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int CNT_W  = 16,
  localparam int PORT_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  xfer_len,
  input  logic              to_port,
  input  logic              mode_narrow,
  input  logic              mode_swap,
  input  logic              mode_odd,
  input  logic              port_in_valid,
  output logic              port_in_ready,
  input  logic [PORT_W-1:0] port_in_data,
  output logic              port_out_valid,
  input  logic              port_out_ready,
  output logic [PORT_W-1:0] port_out_data,
  input  logic              byte_in_valid,
  output logic              byte_in_ready,
  input  logic [LANE_W-1:0] byte_in_data,
  output logic              byte_out_valid,
  input  logic              byte_out_ready,
  output logic [LANE_W-1:0] byte_out_data,
  output logic              busy
);

  // Named internal events, shared with the bound checker.
  logic             start_ok;
  logic             byte_fire;
  logic             cnt_busy;
  logic [CNT_W-1:0] remaining;
  logic             m_to_port;
  logic             m_narrow;
  logic             m_swap;
  logic             slot;
  logic             last_in_word;
  logic             word_done;
  logic             lane_high;

  assign busy      = cnt_busy || port_out_valid;
  assign start_ok  = start && !busy;
  assign lane_high = lane_hi(m_narrow, m_swap, slot);
  assign byte_in_ready = cnt_busy && m_to_port && !port_out_valid;
  assign byte_fire = m_to_port ? (byte_in_valid && byte_in_ready)
                               : (byte_out_valid && byte_out_ready);

  lane_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (start_ok),
    .len          (xfer_len),
    .to_port      (to_port),
    .narrow       (mode_narrow),
    .swap         (mode_swap),
    .odd          (mode_odd),
    .byte_fire    (byte_fire),
    .cnt_busy     (cnt_busy),
    .remaining    (remaining),
    .m_to_port    (m_to_port),
    .m_narrow     (m_narrow),
    .m_swap       (m_swap),
    .slot         (slot),
    .last_in_word (last_in_word),
    .word_done    (word_done)
  );

  lane_seq_unpack #(.LANE_W(LANE_W)) u_unpack (
    .active         (cnt_busy && !m_to_port),
    .port_in_valid  (port_in_valid),
    .port_in_data   (port_in_data),
    .lane_high      (lane_high),
    .last_in_word   (last_in_word),
    .byte_out_ready (byte_out_ready),
    .byte_out_valid (byte_out_valid),
    .byte_out_data  (byte_out_data),
    .port_in_ready  (port_in_ready)
  );

  lane_seq_pack #(.LANE_W(LANE_W)) u_pack (
    .clk            (clk),
    .rst_n          (rst_n),
    .clear          (start_ok),
    .byte_fire      (byte_fire && m_to_port),
    .lane_high      (lane_high),
    .word_done      (word_done && m_to_port),
    .byte_in_data   (byte_in_data),
    .port_out_ready (port_out_ready),
    .port_out_valid (port_out_valid),
    .port_out_data  (port_out_data)
  );

endmodule

// File: rtl/lane_seq_chk.sv
`timescale 1ns/1ps
module lane_seq_chk #(
  parameter int LANE_W = 8,
  parameter int CNT_W  = 16,
  localparam int PORT_W = 2 * LANE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              byte_fire,
  input logic [CNT_W-1:0]  remaining,
  input logic              port_in_ready,
  input logic              byte_out_valid,
  input logic              byte_out_ready,
  input logic              byte_in_ready,
  input logic              port_out_valid,
  input logic              port_out_ready,
  input logic [PORT_W-1:0] port_out_data,
  input logic              m_narrow
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!byte_out_valid && !byte_in_ready && !port_in_ready));

  // R2
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !byte_fire) |=> $stable(remaining));

  // R7
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_out_valid && m_narrow) |-> (port_out_data[PORT_W-1:LANE_W] == '0));

  // R8
  word_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_in_ready |-> (byte_out_valid && byte_out_ready));

  // R9
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_out_valid && !port_out_ready) |=> (port_out_valid && $stable(port_out_data)));

  // R9
  no_byte_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_out_valid |-> !byte_in_ready);

  // R10
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_fire |=> (remaining == $past(remaining) - CNT_W'(1)));

endmodule

bind lane_seq_top lane_seq_chk #(.LANE_W(LANE_W), .CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start          (start),
  .busy           (busy),
  .byte_fire      (byte_fire),
  .remaining      (remaining),
  .port_in_ready  (port_in_ready),
  .byte_out_valid (byte_out_valid),
  .byte_out_ready (byte_out_ready),
  .byte_in_ready  (byte_in_ready),
  .port_out_valid (port_out_valid),
  .port_out_ready (port_out_ready),
  .port_out_data  (port_out_data),
  .m_narrow       (m_narrow)
);

// File: tb/lane_seq_top_bench.sv
`timescale 1ns/1ps
module lane_seq_top_bench;

  localparam int LANE_W = 8;
  localparam int CNT_W  = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] xfer_len = '0;
  logic        to_port = 1'b0;
  logic        mode_narrow = 1'b0;
  logic        mode_swap = 1'b0;
  logic        mode_odd = 1'b0;
  logic        port_in_valid = 1'b0;
  logic        port_in_ready;
  logic [15:0] port_in_data = '0;
  logic        port_out_valid;
  logic        port_out_ready = 1'b0;
  logic [15:0] port_out_data;
  logic        byte_in_valid = 1'b0;
  logic        byte_in_ready;
  logic [7:0]  byte_in_data = '0;
  logic        byte_out_valid;
  logic        byte_out_ready = 1'b0;
  logic [7:0]  byte_out_data;
  logic        busy;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  lane_seq_top #(.LANE_W(LANE_W), .CNT_W(CNT_W)) u_lane_seq_top (
    .clk(clk), .rst_n(rst_n), .start(start), .xfer_len(xfer_len),
    .to_port(to_port), .mode_narrow(mode_narrow), .mode_swap(mode_swap),
    .mode_odd(mode_odd), .port_in_valid(port_in_valid),
    .port_in_ready(port_in_ready), .port_in_data(port_in_data),
    .port_out_valid(port_out_valid), .port_out_ready(port_out_ready),
    .port_out_data(port_out_data), .byte_in_valid(byte_in_valid),
    .byte_in_ready(byte_in_ready), .byte_in_data(byte_in_data),
    .byte_out_valid(byte_out_valid), .byte_out_ready(byte_out_ready),
    .byte_out_data(byte_out_data), .busy(busy)
  );

  // Stimulus and expectation vector: port words w*, packed result words p*,
  // byte stream in order with byte k at bits [8k+7:8k].
  typedef struct packed {
    logic        nar;
    logic        swp;
    logic        odd;
    logic [3:0]  len;
    logic [1:0]  nw;
    logic [15:0] w0;
    logic [15:0] w1;
    logic [15:0] p0;
    logic [15:0] p1;
    logic [31:0] bytes;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 4'd4, 2'd2, 16'hA1B2, 16'hC3D4, 16'hA1B2, 16'hC3D4, 32'hC3D4A1B2},
    '{1'b0, 1'b1, 1'b0, 4'd4, 2'd2, 16'hA1B2, 16'hC3D4, 16'hA1B2, 16'hC3D4, 32'hD4C3B2A1},
    '{1'b0, 1'b0, 1'b1, 4'd3, 2'd2, 16'hA1B2, 16'hC3D4, 16'hA100, 16'hC3D4, 32'h00C3D4A1},
    '{1'b0, 1'b1, 1'b1, 4'd3, 2'd2, 16'hA1B2, 16'hC3D4, 16'h00B2, 16'hC3D4, 32'h00D4C3B2},
    '{1'b0, 1'b0, 1'b0, 4'd3, 2'd2, 16'hA1B2, 16'hC3D4, 16'hA1B2, 16'h00D4, 32'h00D4A1B2},
    '{1'b0, 1'b1, 1'b0, 4'd3, 2'd2, 16'hA1B2, 16'hC3D4, 16'hA1B2, 16'hC300, 32'h00C3B2A1},
    '{1'b1, 1'b0, 1'b0, 4'd2, 2'd2, 16'hA1B2, 16'hC3D4, 16'h00B2, 16'h00D4, 32'h0000D4B2},
    '{1'b1, 1'b1, 1'b1, 4'd2, 2'd2, 16'hA1B2, 16'hC3D4, 16'h00B2, 16'h00D4, 32'h0000D4B2},
    '{1'b0, 1'b0, 1'b1, 4'd1, 2'd1, 16'hA1B2, 16'hC3D4, 16'hA100, 16'h0000, 32'h000000A1},
    '{1'b0, 1'b1, 1'b1, 4'd1, 2'd1, 16'hA1B2, 16'hC3D4, 16'h00B2, 16'h0000, 32'h000000B2},
    '{1'b0, 1'b1, 1'b0, 4'd1, 2'd1, 16'hA1B2, 16'hC3D4, 16'hA100, 16'h0000, 32'h000000A1}
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.nar) return "R7";
    if (v.odd) return "R5";
    if (v.len[0]) return "R6";
    if (v.swp) return "R4";
    return "R3";
  endfunction

  function automatic logic [15:0] word_of(input vec_t v, input int idx);
    if (idx == 0) return v.w0;
    if (idx == 1) return v.w1;
    return 16'hEEEE;
  endfunction

  function automatic logic [15:0] packed_of(input vec_t v, input int idx);
    return (idx == 0) ? v.p0 : v.p1;
  endfunction

  task automatic begin_xfer(input vec_t v, input logic dir);
    mode_narrow = v.nar;
    mode_swap   = v.swp;
    mode_odd    = v.odd;
    to_port     = dir;
    xfer_len    = 16'(v.len);
    start       = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Split port words into bytes; poke pulses start with altered modes in mid-transfer.
  task automatic run_unpack(input vec_t v, input string tag, input bit poke);
    int k = 0;
    int widx = 0;
    begin_xfer(v, 1'b0);
    for (int guard = 0; guard < 40 && k < int'(v.len); guard++) begin
      port_in_valid  = 1'b1;
      port_in_data   = word_of(v, widx);
      byte_out_ready = (guard % 3 != 1);
      if (poke && guard == 3) begin
        start = 1'b1; mode_swap = ~v.swp; to_port = 1'b1; xfer_len = 16'd1; mode_odd = 1'b1;
      end else begin
        start = 1'b0;
      end
      #1;
      if (byte_out_valid && byte_out_ready) begin
        chk(byte_out_data == v.bytes[8*k +: 8], poke ? "R2" : tag,
            32'(byte_out_data), 32'(v.bytes[8*k +: 8]));
        k++;
      end
      if (port_in_ready) widx++;
      @(negedge clk);
    end
    start = 1'b0;
    port_in_valid = 1'b0;
    byte_out_ready = 1'b0;
    #1;
    chk(widx == int'(v.nw), "R8", 32'(widx), 32'(v.nw));
    chk(!busy, "R10", 32'(busy), 32'd0);
    @(negedge clk);
  endtask

  // Pack stream bytes into port words, with backpressure on the port side.
  task automatic run_pack(input vec_t v, input string tag);
    int k = 0;
    int widx = 0;
    begin_xfer(v, 1'b1);
    for (int guard = 0; guard < 40 && widx < int'(v.nw); guard++) begin
      byte_in_valid  = (k < int'(v.len));
      byte_in_data   = (k < int'(v.len)) ? v.bytes[8*k +: 8] : 8'h5A;
      port_out_ready = (guard % 4 != 2);
      #1;
      if (byte_in_valid && byte_in_ready) k++;
      if (port_out_valid && port_out_ready) begin
        chk(port_out_data == packed_of(v, widx), tag,
            32'(port_out_data), 32'(packed_of(v, widx)));
        widx++;
      end
      @(negedge clk);
    end
    byte_in_valid = 1'b0;
    port_out_ready = 1'b0;
    #1;
    chk(k == int'(v.len), "R10", 32'(k), 32'(v.len));
    chk(widx == int'(v.nw), "R9", 32'(widx), 32'(v.nw));
    chk(!busy, "R10", 32'(busy), 32'd0);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R10 watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    port_in_valid = 1'b1;
    byte_in_valid = 1'b1;
    #1;
    // R1: idle after reset, stimulus on both sides is not taken
    chk(!busy, "R1", 32'(busy), 32'd0);
    chk(!byte_out_valid && !port_in_ready, "R1", {30'd0, byte_out_valid, port_in_ready}, 32'd0);
    chk(!byte_in_ready && !port_out_valid, "R1", {30'd0, byte_in_ready, port_out_valid}, 32'd0);
    @(negedge clk);
    port_in_valid = 1'b0;
    byte_in_valid = 1'b0;

    for (int i = 0; i < NV; i++) begin
      run_unpack(VECS[i], tag_of(VECS[i]), 1'b0);
      run_pack(VECS[i], tag_of(VECS[i]));
    end

    // R2: start and mode changes during a transfer do not disturb it
    run_unpack(VECS[0], "R2", 1'b1);

    // R2: zero length starts nothing
    xfer_len = 16'd0; to_port = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    port_in_valid = 1'b1;
    byte_out_ready = 1'b1;
    #1;
    chk(!busy && !byte_out_valid, "R2", {30'd0, busy, byte_out_valid}, 32'd0);
    @(negedge clk);
    port_in_valid = 1'b0;
    byte_out_ready = 1'b0;

    // R1: back to idle after all transfers
    #1;
    chk(!port_out_valid && !byte_in_ready, "R1", {30'd0, port_out_valid, byte_in_ready}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule